// File: doc/BRIEF.md
# Prescaled Interval Timer with Free-Running Counter

This block is a timer peripheral with a 32-bit register interface and two counters. The first is an interval down-counter. Software gives it a start value. It steps once per prescaled tick. When it passes zero it raises an interrupt flag and restarts from a reload value. The tick comes from a programmable base divider followed by a fixed divide-by-1, 16 or 256 stage. The counter can run 16 or 32 bits wide. A single input pin can freeze it when halting is armed in the control word.

The second counter is a free-running up-counter. It is enabled and divided separately by an 8-bit field of the same control word, and it advances once every (field + 1) clock cycles. Software reads it as a timebase.

Accesses are single-cycle writes. Read data is registered: it appears one cycle after the address is presented and reflects the state before that edge. Word index = byte address bits [5:2].

Top module: `dual_timer`

## Requirements
- R1: After synchronous reset, these registers read 0: the count (index 1), the control word (index 2), the raw flag (index 4), the reload value (index 6) and the free count (index 8). `irq` is low.
- R2: A write to index 0 sets both the count and the reload value to the written data. Writes to index 1 have no effect on the count.
- R3: On each tick, a count of zero sets the raw flag and copies the reload value into the count. Any other count decrements by one. With start value N, the flag rises on tick N+1 and the period is N+1 ticks.
- R4: Control bits [3:2] divide the base tick: 00 by 1, 01 by 16, 10 by 256. 11 behaves as 00.
- R5: When control bit 1 is 0 (16-bit mode), only count bits [15:0] decrement and are tested for zero, and bits [31:16] hold. When bit 1 is 1, all 32 bits take part.
- R6: `irq` and the masked register (index 5, bit 0) equal the raw flag ANDed with control bit 5. Any write to index 3 clears the raw flag; a wrap in the same cycle wins.
- R7: With control bit 7 clear, the count and its prescaler do not move.
- R8: With control bit 8 set and `dbg_halt` high, the count holds. `dbg_halt` without bit 8 has no effect.
- R9: With control bit 9 set, the free count (index 8) increments once every (bits [23:16] + 1) cycles, independent of the down-counter. With bit 9 clear it holds.
- R10: The base tick occurs every (predivider + 1) cycles, where the predivider is index 7 bits [PD_W-1:0]. A write to index 0 restarts both divider stages.
- R11: The control word reads back with only bits 23:16, 9, 8, 7, 5, 3:2 and 1 kept. The reload and predivider registers read back what was written, the predivider masked to PD_W bits. Indices 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 6 | Byte address; bits [5:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dbg_halt | input | 1 | Debug halt request |
| irq | output | 1 | Masked interrupt |

## Verification
The count is swept over every divider code crossed with two predivider values. It is sampled at irregular, widening intervals and compared with an arithmetic model of ticks since enable modulo the period. This separates code 01 from 10, and 11 from 00, and shows whether the predivider multiplies the stage division. Back-to-back reads around tick N+1 pin the exact flag edge. A start value with nonzero upper bits in 16-bit mode can only raise the flag after four ticks if the upper half is excluded from the zero test. Pairs of reads a fixed distance apart show halting and free-counter rates, independent of the absolute start time.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int IDX_W = 4;

  localparam logic [IDX_W-1:0] IX_LOAD   = 4'd0;
  localparam logic [IDX_W-1:0] IX_VALUE  = 4'd1;
  localparam logic [IDX_W-1:0] IX_CTRL   = 4'd2;
  localparam logic [IDX_W-1:0] IX_ICLR   = 4'd3;
  localparam logic [IDX_W-1:0] IX_RAW    = 4'd4;
  localparam logic [IDX_W-1:0] IX_MASKED = 4'd5;
  localparam logic [IDX_W-1:0] IX_RELOAD = 4'd6;
  localparam logic [IDX_W-1:0] IX_PREDIV = 4'd7;
  localparam logic [IDX_W-1:0] IX_FREE   = 4'd8;

  typedef struct packed {
    logic [7:0] free_div;
    logic       free_en;
    logic       halt_en;
    logic       cnt_en;
    logic       irq_en;
    logic [1:0] psel;
    logic       wide;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.free_div = w[23:16];
    c.free_en  = w[9];
    c.halt_en  = w[8];
    c.cnt_en   = w[7];
    c.irq_en   = w[5];
    c.psel     = w[3:2];
    c.wide     = w[1];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    return {8'h00, c.free_div, 6'h00, c.free_en, c.halt_en, c.cnt_en,
            1'b0, c.irq_en, 1'b0, c.psel, c.wide, 1'b0};
  endfunction
endpackage

// File: rtl/dtmr_tick_gen.sv
module dtmr_tick_gen #(
  parameter int PD_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            run,
  input  logic [PD_W-1:0] prediv,
  input  logic [1:0]      psel,
  output logic            tick
);
  logic [PD_W-1:0] pd_q;
  logic [7:0]      ps_q;
  logic [7:0]      mask;
  logic            base;

  always_comb begin
    case (psel)
      2'b01:   mask = 8'h0F;
      2'b10:   mask = 8'hFF;
      default: mask = 8'h00;
    endcase
  end

  assign base = (pd_q >= prediv);
  assign tick = run && base && ((ps_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pd_q <= '0;
      ps_q <= '0;
    end else if (run) begin
      if (base) begin
        pd_q <= '0;
        ps_q <= ps_q + 8'd1;
      end else begin
        pd_q <= pd_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dtmr_down.sv
module dtmr_down #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_wr,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] reload_val,
  input  logic          tick,
  input  logic          wide,
  output logic [DW-1:0] count,
  output logic          wrap
);
  localparam int HALF = DW / 2;

  logic at_zero;

  assign at_zero = wide ? (count == '0) : (count[HALF-1:0] == '0);
  assign wrap    = tick && at_zero;

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (load_wr)
      count <= load_val;
    else if (wrap)
      count <= reload_val;
    else if (tick) begin
      if (wide)
        count <= count - 1'b1;
      else
        count <= {count[DW-1:HALF], count[HALF-1:0] - 1'b1};
    end
  end
endmodule

// File: rtl/dtmr_free.sv
module dtmr_free #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [7:0]    div,
  output logic [DW-1:0] count
);
  logic [7:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      count   <= '0;
    end else if (!en) begin
      phase_q <= '0;
    end else if (phase_q >= div) begin
      phase_q <= '0;
      count   <= count + 1'b1;
    end else begin
      phase_q <= phase_q + 8'd1;
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int DATA_W = 32,
  parameter int PD_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [5:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  output logic              irq
);
  import dtmr_pkg::*;

  logic [IDX_W-1:0]  idx;
  logic              wr;
  logic              load_wr, reload_wr, iclr_wr;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] reload_q;
  logic [PD_W-1:0]   prediv_q;
  logic              raw_q;
  logic              run, halt_on, tick, wrap;
  logic [DATA_W-1:0] count, free_cnt;
  logic [DATA_W-1:0] rd_mux;

  assign idx       = bus_addr[5:2];
  assign wr        = bus_sel && bus_we;
  assign load_wr   = wr && (idx == IX_LOAD);
  assign reload_wr = wr && (idx == IX_RELOAD);
  assign iclr_wr   = wr && (idx == IX_ICLR);
  assign halt_on   = ctrl_q.halt_en && dbg_halt;
  assign run       = ctrl_q.cnt_en && !halt_on;
  assign irq       = raw_q && ctrl_q.irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      prediv_q <= '0;
      raw_q    <= 1'b0;
    end else begin
      if (wr && idx == IX_CTRL)   ctrl_q   <= ctrl_unpack(bus_wdata);
      if (load_wr || reload_wr)   reload_q <= bus_wdata;
      if (wr && idx == IX_PREDIV) prediv_q <= bus_wdata[PD_W-1:0];
      if (wrap)                   raw_q    <= 1'b1;
      else if (iclr_wr)           raw_q    <= 1'b0;
    end
  end

  dtmr_tick_gen #(.PD_W(PD_W)) u_tick (
    .clk(clk), .rst(rst), .restart(load_wr), .run(run),
    .prediv(prediv_q), .psel(ctrl_q.psel), .tick(tick)
  );

  dtmr_down #(.DW(DATA_W)) u_down (
    .clk(clk), .rst(rst), .load_wr(load_wr), .load_val(bus_wdata),
    .reload_val(reload_q), .tick(tick), .wide(ctrl_q.wide),
    .count(count), .wrap(wrap)
  );

  dtmr_free #(.DW(DATA_W)) u_free (
    .clk(clk), .rst(rst), .en(ctrl_q.free_en), .div(ctrl_q.free_div),
    .count(free_cnt)
  );

  always_comb begin
    case (idx)
      IX_VALUE:  rd_mux = count;
      IX_CTRL:   rd_mux = ctrl_pack(ctrl_q);
      IX_RAW:    rd_mux = {{(DATA_W-1){1'b0}}, raw_q};
      IX_MASKED: rd_mux = {{(DATA_W-1){1'b0}}, irq};
      IX_RELOAD: rd_mux = reload_q;
      IX_PREDIV: rd_mux = {{(DATA_W-PD_W){1'b0}}, prediv_q};
      IX_FREE:   rd_mux = free_cnt;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          load_wr,
  input logic          reload_wr,
  input logic          iclr_wr,
  input logic          wrap,
  input logic          run,
  input logic          halt_on,
  input logic [DW-1:0] count,
  input logic [DW-1:0] reload,
  input logic          raw,
  input logic          irq,
  input logic [DW-1:0] free
);
  // R3: a wrap restarts from the reload value and raises the flag
  a_r3_wrap_reload: assert property (@(posedge clk) disable iff (rst)
    (wrap && !load_wr && !reload_wr) |=> (raw && count == $past(reload)));

  // R6: clear write drops the flag when no wrap coincides
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (iclr_wr && !wrap) |=> !raw);

  // R6: interrupt never without the raw flag
  a_r6_irq_needs_raw: assert property (@(posedge clk) disable iff (rst)
    irq |-> raw);

  // R7: a stopped counter keeps its value
  a_r7_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_wr) |=> $stable(count));

  // R8: armed halt with the pin high freezes the count
  a_r8_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    (halt_on && !load_wr) |=> $stable(count));

  // R9: free count only holds or steps by one
  a_r9_free_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (free == $past(free) || free == $past(free) + 1'b1));
endmodule

bind dual_timer dual_timer_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .load_wr(load_wr), .reload_wr(reload_wr),
  .iclr_wr(iclr_wr), .wrap(wrap), .run(run), .halt_on(halt_on),
  .count(count), .reload(reload_q), .raw(raw_q), .irq(irq), .free(free_cnt)
);

// File: tb/dual_timer_test.sv
`timescale 1ns/1ps
module dual_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        irq;

  int cyc = 0;
  int c_w = 0;
  int c_r = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] EN = 32'h80, IE = 32'h20, WIDE = 32'h2,
                          HALT = 32'h100, FREE = 32'h200;

  dual_timer uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ix, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = 6'(ix * 4); bus_wdata = d;
    @(posedge clk); #1; c_w = cyc;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input int ix, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = 6'(ix * 4);
    @(posedge clk); #1; d = bus_rdata; c_r = cyc;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; idle(2); rst = 0;
  endtask

  function automatic logic [31:0] down_exp(input int n, input int t_div, input int e);
    int t;
    t = e / t_div;
    return 32'(n - (t % (n + 1)));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int c_s;
    idle(3); rst = 0; idle(1);

    // R1 reset state
    rd(1, v); chk("R1 count", v, 0);
    rd(2, v); chk("R1 ctrl", v, 0);
    rd(4, v); chk("R1 raw", v, 0);
    rd(6, v); chk("R1 reload", v, 0);
    rd(8, v); chk("R1 free", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R11 read-back
    wr(2, 32'hFFFF_FFFF); rd(2, v); chk("R11 ctrl mask", v, 32'h00FF_03AE);
    wr(2, 0);
    wr(6, 32'h1234_5678); rd(6, v); chk("R11 reload", v, 32'h1234_5678);
    wr(7, 32'hFFFF_FFFF); rd(7, v); chk("R11 prediv", v, 32'h0000_03FF);
    rd(9, v);  chk("R11 idx9", v, 0);
    rd(15, v); chk("R11 idx15", v, 0);
    do_reset();

    // R2 load, R7 hold while disabled
    wr(0, 32'h77); rd(1, v); chk("R2 load count", v, 32'h77);
    rd(6, v); chk("R2 load reload", v, 32'h77);
    wr(1, 32'h99); rd(1, v); chk("R2 value ro", v, 32'h77);
    idle(20); rd(1, v); chk("R7 disabled hold", v, 32'h77);

    // R3 R4 R10 sweep
    for (int ps = 0; ps < 4; ps++) begin
      for (int pdi = 0; pdi < 2; pdi++) begin
        int pd, d, tdiv;
        pd = pdi * 2;
        d = (ps == 1) ? 16 : (ps == 2) ? 256 : 1;
        tdiv = (pd + 1) * d;
        wr(2, WIDE);
        wr(3, 0);
        wr(7, 32'(pd));
        wr(0, 32'd5);
        wr(2, EN | WIDE | 32'(ps << 2));
        c_s = c_w;
        for (int k = 0; k < 6; k++) begin
          idle(k * k * 41);
          rd(1, v);
          chk($sformatf("R4 R10 psel%0d pd%0d count", ps, pd), v,
              down_exp(5, tdiv, c_r - 1 - c_s));
          rd(4, v);
          chk($sformatf("R3 psel%0d pd%0d raw", ps, pd), v,
              ((c_r - 1 - c_s) / tdiv >= 6) ? 32'd1 : 32'd0);
        end
      end
    end

    // R3 exact flag edge, R6 irq
    wr(2, WIDE); wr(3, 0); wr(7, 0); wr(0, 32'd20);
    wr(2, EN | IE | WIDE); c_s = c_w;
    idle(20);
    rd(4, v); chk("R3 raw before N+1", v, 0);
    rd(4, v); chk("R3 raw at N+1", v, 1);
    chk("R6 irq up", {31'b0, irq}, 1);
    rd(1, v); chk("R3 reloaded", v, down_exp(20, 1, c_r - 1 - c_s));

    // R6 mask and clear
    wr(2, IE | WIDE);
    chk("R6 irq enabled", {31'b0, irq}, 1);
    rd(5, v); chk("R6 masked set", v, 1);
    wr(2, WIDE);
    chk("R6 irq masked off", {31'b0, irq}, 0);
    rd(5, v); chk("R6 masked off", v, 0);
    rd(4, v); chk("R6 raw kept", v, 1);
    wr(3, 32'h0); rd(4, v); chk("R6 raw cleared", v, 0);
    wr(2, IE | WIDE);
    chk("R6 irq after clear", {31'b0, irq}, 0);

    // R5 16-bit mode
    wr(2, 0); wr(3, 0); wr(0, 32'h0001_0003);
    wr(2, EN); c_s = c_w;
    idle(3); rd(1, v); chk("R5 low zero", v, 32'h0001_0000);
    rd(1, v); chk("R5 reload", v, 32'h0001_0003);
    rd(4, v); chk("R5 raw", v, 1);
    rd(1, v); chk("R5 upper held", v, 32'h0001_0001);

    // R8 debug halt
    wr(2, WIDE); wr(0, 32'd50); dbg_halt = 1;
    wr(2, EN | HALT | WIDE);
    idle(10); rd(1, v); chk("R8 halted", v, 50);
    rd(1, v); idle(5); rd(1, v2); chk("R8 halted pair", v2, v);
    dbg_halt = 0;
    rd(1, v); idle(5); rd(1, v2); chk("R8 bit without pin", v2, v - 6);
    dbg_halt = 1; wr(2, EN | WIDE);
    rd(1, v); idle(5); rd(1, v2); chk("R8 pin without bit", v2, v - 6);
    dbg_halt = 0;

    // R9 free-running counter
    do_reset();
    wr(2, FREE | (32'd2 << 16)); c_s = c_w;
    for (int k = 0; k < 5; k++) begin
      idle(k * 7);
      rd(8, v); chk("R9 free div3", v, 32'((c_r - 1 - c_s) / 3));
    end
    rd(1, v); chk("R9 down untouched", v, 0);
    wr(2, FREE);
    rd(8, v); rd(8, v2); chk("R9 free div1", v2, v + 1);
    wr(2, 0);
    rd(8, v); idle(9); rd(8, v2); chk("R9 free hold", v2, v);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule